// File: doc/BRIEF.md
# Multichannel Audio Summer and Mixer

This block sits in a multichannel audio record path and processes one frame of eight signed 24-bit samples at a time. A 2-bit mode input picks the processing. In the pair mode, neighbouring channels are averaged together. In the quad mode, the first four channels are averaged. Either mode lowers the uncorrelated noise in the channels it covers.

When averaging is off, a 4x4 matrix of programmable signed gains mixes input channels 1 to 4 into output channels 1 to 4. Each gain is in Q1.31 format. Each mixer result is rounded once and then clipped to the 24-bit range. Any channel that the active mode does not cover is copied to the output unchanged.

A frame is presented with a one-cycle valid strobe. Its result appears two cycles later with its own strobe, and it stays on the output until the next result replaces it. Gains are loaded through a simple write port. Each frame samples the gain matrix exactly once, so a write never splits a frame.

Top module: `audio_chan_mixer`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0. The gain matrix is the identity: diagonal gains are 0x7FFFFFFF and all others are 0, so in mode 00 every output equals its input.
- R2: In mode 01, outputs 1 and 2 both equal floor((in1+in2)/2). Outputs 3 and 4 both equal floor((in3+in4)/2). Outputs 5 and 6 both equal floor((in5+in6)/2).
- R3: In mode 10, outputs 1 to 4 each equal floor((in1+in2+in3+in4)/4).
- R4: In mode 00, output k (k = 1 to 4) equals the sum over j of in_j times g(k,j). That sum has 2^30 added, is floored after division by 2^31, and is then clipped to [-8388608, 8388607]. Gain g(k,j) sits at coef_addr = 4*(k-1)+(j-1), so addr bits [3:2] select the output and bits [1:0] select the input.
- R5: Mode 11 gives exactly the same result as mode 00.
- R6: Channels that the mode does not cover pass through unchanged: 7 and 8 in mode 01, and 5 to 8 in the other modes.
- R7: A frame uses the gains held before its valid cycle. A write issued in the same cycle as in_valid affects only later frames.
- R8: out_valid is high exactly two cycles after each cycle in which in_valid is high, and low otherwise.
- R9: out_data keeps its value in every cycle in which out_valid is low.

Channel c (c = 1 to 8) occupies bits [24*c-1 : 24*(c-1)] of in_data and out_data, and samples are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input frame strobe |
| in_data | input | 192 | Eight packed input samples |
| sum_mode | input | 2 | 00 mixer, 01 pairs, 10 quad, 11 as 00 |
| coef_we | input | 1 | Gain write enable |
| coef_addr | input | 4 | Gain index: output*4 + input |
| coef_data | input | 32 | Q1.31 gain value |
| out_valid | output | 1 | Output frame strobe |
| out_data | output | 192 | Eight packed output samples |

## Verification
The identity matrix is tried with random frames, which shows that the gains and channel placement come up correctly from reset. Random frames in the pair and quad modes separate floor averaging from rounding and show the channel mapping of each mode. Random gain matrices in modes 00 and 11 test the whole matrix path. Directed cases cover the rest:
- a half gain on odd values, which exposes the round-half-up rule;
- full-scale positive and negative inputs with unity gains, which reach both clip limits;
- a gain write in the same cycle as a frame, which shows the per-frame gain sampling.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  parameter int SMP_W = 24;
  parameter int CF_W  = 32;
  parameter int FRAC  = CF_W - 1;
  parameter int MIX_N = 4;
  localparam int PROD_W = SMP_W + CF_W;
  localparam int ACC_W  = PROD_W + $clog2(MIX_N) + 1;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [CF_W-1:0]   coef_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef enum logic [1:0] {
    SUM_OFF  = 2'b00,
    SUM_PAIR = 2'b01,
    SUM_QUAD = 2'b10,
    SUM_RSVD = 2'b11
  } sum_mode_e;

  // floor of the mean of two samples
  function automatic smp_t avg2(input smp_t a, input smp_t b);
    logic signed [SMP_W:0] s;
    s = a + b;
    return smp_t'(s >>> 1);
  endfunction

  // floor of the mean of four samples
  function automatic smp_t avg4(input smp_t a, input smp_t b,
                                input smp_t c, input smp_t d);
    logic signed [SMP_W+1:0] s;
    s = a + b + c + d;
    return smp_t'(s >>> 2);
  endfunction

  // round half up at the Q1.31 point, then clip to the sample range
  function automatic smp_t round_sat(input acc_t acc);
    acc_t r;
    acc_t hi;
    acc_t lo;
    hi = acc_t'((2 ** (SMP_W - 1)) - 1);
    lo = -acc_t'(2 ** (SMP_W - 1));
    r  = (acc + (acc_t'(1) <<< (FRAC - 1))) >>> FRAC;
    if (r > hi) return smp_t'(hi);
    if (r < lo) return smp_t'(lo);
    return smp_t'(r);
  endfunction
endpackage

// File: rtl/mix_coef_bank.sv
module mix_coef_bank
  import mixer_pkg::*;
#(
  parameter int N = MIX_N,
  localparam int NG = N * N,
  localparam int AW = $clog2(NG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  coef_t         coef_data,
  output coef_t         gains [NG]
);
  localparam coef_t UNITY = coef_t'({1'b0, {(CF_W-1){1'b1}}});

  for (genvar r = 0; r < NG; r++) begin : g_reg
    localparam coef_t RST_V = ((r / N) == (r % N)) ? UNITY : coef_t'(0);
    always_ff @(posedge clk) begin
      if (!rst_n)
        gains[r] <= RST_V;
      else if (coef_we && (coef_addr == AW'(r)))
        gains[r] <= coef_data;
    end
  end

  AST_COEF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> (gains[$past(coef_addr)] == $past(coef_data)));  // R7
endmodule

// File: rtl/mix_product_stage.sv
module mix_product_stage
  import mixer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int N = MIX_N,
  localparam int NG = N * N
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NCH*SMP_W-1:0]   in_data,
  input  logic [1:0]             sum_mode,
  input  coef_t                  gains [NG],
  output logic                   v1,
  output sum_mode_e              mode1,
  output smp_t                   s1 [NCH],
  output prod_t                  p1 [NG]
);
  smp_t  smp_in [NCH];
  prod_t prod   [NG];

  for (genvar c = 0; c < NCH; c++) begin : g_unpack
    assign smp_in[c] = smp_t'(in_data[c*SMP_W +: SMP_W]);
  end

  // gain (k,j) scales input j for output k
  for (genvar g = 0; g < NG; g++) begin : g_mul
    assign prod[g] = prod_t'(smp_in[g % N]) * prod_t'(gains[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      mode1 <= SUM_OFF;
      for (int c = 0; c < NCH; c++) s1[c] <= '0;
      for (int g = 0; g < NG; g++)  p1[g] <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        mode1 <= sum_mode_e'(sum_mode);
        for (int c = 0; c < NCH; c++) s1[c] <= smp_in[c];
        for (int g = 0; g < NG; g++)  p1[g] <= prod[g];
      end
    end
  end

  AST_FRAME_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mode1) && (p1[0] == $past(p1[0]))));  // R7
endmodule

// File: rtl/mix_combine_stage.sv
module mix_combine_stage
  import mixer_pkg::*;
#(
  parameter int NCH = 8,
  parameter int N = MIX_N,
  localparam int NG = N * N,
  localparam int NPAIR = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      v1,
  input  sum_mode_e mode1,
  input  smp_t      s1 [NCH],
  input  prod_t     p1 [NG],
  output logic      out_valid,
  output smp_t      out_q [NCH]
);
  smp_t res [NCH];
  smp_t quad_avg;
  smp_t mix_res [N];

  assign quad_avg = avg4(s1[0], s1[1], s1[2], s1[3]);

  for (genvar k = 0; k < N; k++) begin : g_mix
    always_comb begin
      acc_t acc;
      acc = '0;
      for (int j = 0; j < N; j++) acc = acc + acc_t'(p1[k*N + j]);
      mix_res[k] = round_sat(acc);
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) res[c] = s1[c];
    case (mode1)
      SUM_PAIR: begin
        for (int p = 0; p < NPAIR; p++) begin
          res[2*p]   = avg2(s1[2*p], s1[2*p+1]);
          res[2*p+1] = avg2(s1[2*p], s1[2*p+1]);
        end
      end
      SUM_QUAD: begin
        for (int c = 0; c < 4; c++) res[c] = quad_avg;
      end
      default: begin
        for (int k = 0; k < N; k++) res[k] = mix_res[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      for (int c = 0; c < NCH; c++) out_q[c] <= '0;
    end else begin
      out_valid <= v1;
      if (v1)
        for (int c = 0; c < NCH; c++) out_q[c] <= res[c];
    end
  end

  AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && mode1 == SUM_PAIR) |=>
      (out_q[0] == out_q[1] && out_q[2] == out_q[3] && out_q[4] == out_q[5]));  // R2
  AST_QUAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && mode1 == SUM_QUAD) |=>
      (out_q[0] == out_q[1] && out_q[1] == out_q[2] && out_q[2] == out_q[3]));  // R3
  AST_PASS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    v1 |=> (out_q[NCH-1] == $past(s1[NCH-1])));  // R6
endmodule

// File: rtl/audio_chan_mixer.sv
module audio_chan_mixer
  import mixer_pkg::*;
#(
  parameter int NCH = 8,
  localparam int NG = MIX_N * MIX_N,
  localparam int AW = $clog2(NG),
  localparam int DW = NCH * SMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic [1:0]      sum_mode,
  input  logic            coef_we,
  input  logic [AW-1:0]   coef_addr,
  input  logic [CF_W-1:0] coef_data,
  output logic            out_valid,
  output logic [DW-1:0]   out_data
);
  coef_t     gains [NG];
  logic      v1;
  sum_mode_e mode1;
  smp_t      s1 [NCH];
  prod_t     p1 [NG];
  smp_t      out_q [NCH];

  mix_coef_bank #(.N(MIX_N)) u_bank (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_t'(coef_data)), .gains(gains)
  );

  mix_product_stage #(.NCH(NCH), .N(MIX_N)) u_prod (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .sum_mode(sum_mode), .gains(gains), .v1(v1), .mode1(mode1),
    .s1(s1), .p1(p1)
  );

  mix_combine_stage #(.NCH(NCH), .N(MIX_N)) u_comb (
    .clk(clk), .rst_n(rst_n), .v1(v1), .mode1(mode1), .s1(s1), .p1(p1),
    .out_valid(out_valid), .out_q(out_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_pack
    assign out_data[c*SMP_W +: SMP_W] = out_q[c];
  end

  AST_LAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);  // R8
  AST_LAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);  // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));  // R9
endmodule

// File: tb/sim_audio_chan_mixer.sv
module sim_audio_chan_mixer;
  localparam int NCH = 8;
  localparam int SW  = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [NCH*SW-1:0] in_data = '0;
  logic [1:0]       sum_mode = 2'b00;
  logic             coef_we = 1'b0;
  logic [3:0]       coef_addr = '0;
  logic [31:0]      coef_data = '0;
  logic             out_valid;
  logic [NCH*SW-1:0] out_data;

  audio_chan_mixer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .sum_mode(sum_mode), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data)
  );

  int     checks = 0;
  int     errors = 0;
  longint gm [16];
  int     cur [NCH];
  int     expv [NCH];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outch(input int c);
    logic signed [SW-1:0] v;
    v = out_data[c*SW +: SW];
    return int'(v);
  endfunction

  function automatic int rnd_smp();
    logic signed [SW-1:0] v;
    v = SW'($urandom);
    return int'(v);
  endfunction

  function automatic bit is_pass(input int c, input int mode);
    return (mode == 1) ? (c >= 6) : (c >= 4);
  endfunction

  // bench-side statement of the four modes
  task automatic compute(input int mode);
    for (int c = 0; c < NCH; c++) expv[c] = cur[c];
    if (mode == 1) begin
      for (int p = 0; p < 3; p++) begin
        expv[2*p]   = (cur[2*p] + cur[2*p+1]) >>> 1;
        expv[2*p+1] = expv[2*p];
      end
    end else if (mode == 2) begin
      for (int c = 0; c < 4; c++)
        expv[c] = (cur[0] + cur[1] + cur[2] + cur[3]) >>> 2;
    end else begin
      for (int k = 0; k < 4; k++) begin
        longint acc = 0;
        for (int j = 0; j < 4; j++) acc += longint'(cur[j]) * gm[k*4+j];
        acc = (acc + (64'sd1 <<< 30)) >>> 31;
        if (acc > 8388607) acc = 8388607;
        if (acc < -8388608) acc = -8388608;
        expv[k] = int'(acc);
      end
    end
  endtask

  task automatic write_gain(input int addr, input longint val);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 4'(addr); coef_data = 32'(val);
    @(negedge clk);
    coef_we = 1'b0;
    gm[addr] = longint'($signed(32'(val)));
  endtask

  task automatic run_frame(input int mode, input string req,
                           input bit wr, input int waddr, input longint wval);
    int held;
    compute(mode);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) in_data[c*SW +: SW] = SW'(cur[c]);
    sum_mode = 2'(mode);
    in_valid = 1'b1;
    if (wr) begin
      coef_we = 1'b1; coef_addr = 4'(waddr); coef_data = 32'(wval);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (wr) begin
      coef_we = 1'b0;
      gm[waddr] = longint'($signed(32'(wval)));
    end
    chk("R8 valid low after one cycle", out_valid, 0);
    @(negedge clk);
    chk("R8 valid high after two cycles", out_valid, 1);
    for (int c = 0; c < NCH; c++)
      chk(is_pass(c, mode) ? "R6 passthrough" : req, outch(c), expv[c]);
    held = outch(0);
    @(negedge clk);
    chk("R8 valid single cycle", out_valid, 0);
    chk("R9 output held", outch(0), held);
  endtask

  task automatic rand_frame();
    for (int c = 0; c < NCH; c++) cur[c] = rnd_smp();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < 16; g++) gm[g] = ((g / 4) == (g % 4)) ? 64'sh7FFFFFFF : 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", out_valid, 0);
    chk("R1 reset data", out_data == '0, 1);
    rst_n = 1'b1;

    // identity after reset
    for (int i = 0; i < 4; i++) begin rand_frame(); run_frame(0, "R1 identity", 0, 0, 0); end
    // averaging modes
    for (int i = 0; i < 6; i++) begin rand_frame(); run_frame(1, "R2 pair avg", 0, 0, 0); end
    for (int i = 0; i < 6; i++) begin rand_frame(); run_frame(2, "R3 quad avg", 0, 0, 0); end
    // random matrices
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 16; g++) write_gain(g, longint'($urandom));
      for (int i = 0; i < 3; i++) begin rand_frame(); run_frame(0, "R4 mixer", 0, 0, 0); end
      for (int i = 0; i < 3; i++) begin rand_frame(); run_frame(3, "R5 reserved as mixer", 0, 0, 0); end
    end
    // rounding: half gain on input 1
    for (int g = 0; g < 16; g++) write_gain(g, 0);
    write_gain(0, 64'h40000000);
    for (int c = 0; c < NCH; c++) cur[c] = 0;
    cur[0] = 3;
    run_frame(0, "R4 round up", 0, 0, 0);
    chk("R4 round 3/2", outch(0), 2);
    cur[0] = -3;
    run_frame(0, "R4 round neg", 0, 0, 0);
    chk("R4 round -3/2", outch(0), -1);
    // saturation both ways
    for (int j = 0; j < 4; j++) write_gain(j, 64'h7FFFFFFF);
    for (int c = 0; c < 4; c++) cur[c] = 8388607;
    run_frame(0, "R4 clip high", 0, 0, 0);
    chk("R4 clip high value", outch(0), 8388607);
    for (int c = 0; c < 4; c++) cur[c] = -8388608;
    run_frame(0, "R4 clip low", 0, 0, 0);
    chk("R4 clip low value", outch(0), -8388608);
    // gain write coinciding with a frame
    write_gain(5, 64'h7FFFFFFF);
    rand_frame();
    run_frame(0, "R7 old gain in frame", 1, 5, 64'h20000000);
    run_frame(0, "R7 new gain next frame", 0, 0, 0);
    // idle stretch keeps the last result
    begin
      int keep = outch(2);
      repeat (5) @(negedge clk);
      chk("R9 idle hold", outch(2), keep);
      chk("R8 idle valid", out_valid, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule